// File: doc/BRIEF.md
# Even-Row Weighted Sum Accumulator

This block keeps a small table of signed samples and, on command, sweeps a two-level iteration nest over it as a single flattened loop. For every outer row it walks all inner positions and accumulates each sample multiplied by its own position. At the last inner position of a row it emits one result word. Even rows report the row's weighted sum divided by twenty. Odd rows report zero.

Samples are loaded through a plain write port while the block is idle. A start pulse launches a run of 400 back-to-back multiply-accumulate steps, one per clock, with no idle cycles between rows. Results leave as single-cycle valid pulses that carry the row index and the data. A done pulse marks the end of the run.

Top module: `ers_accum`

## Requirements
- R1: While idle, a write with address below 20 stores the 5-bit signed two's-complement sample at that address. A write to any address from 20 to 31 changes no stored sample.
- R2: A start pulse while idle makes busy rise on the next clock. Busy then stays high for exactly 400 cycles, during which the nest runs inner index 0..19 for each outer index 0..19, one step per cycle.
- R3: Each step adds sample[j] times j to a 12-bit signed accumulator that wraps modulo 4096. The accumulator is cleared at the step with j = 0, so each row starts from zero.
- R4: The result for row i appears one cycle after step (i, 19) as a one-cycle res_valid pulse with res_index = i. The first result comes 20 cycles after busy rises, and results follow every 20 cycles.
- R5: For even i, res_data is the low 6 bits of the accumulated sum divided by 20, with the quotient truncated toward zero.
- R6: For odd i, res_data is 0.
- R7: done is high for exactly one cycle, the cycle after the result for row 19.
- R8: A start pulse while busy has no effect on the running sweep or its timing.
- R9: A sample write while busy changes no stored sample.
- R10: After reset, busy, res_valid and done are low, and res_index and res_data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Sample write strobe |
| wr_addr | input | 5 | Sample write address |
| wr_data | input | 5 | Signed sample value |
| start | input | 1 | Launch a sweep when idle |
| busy | output | 1 | Sweep in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_index | output | 5 | Outer row index of the result |
| res_data | output | 6 | Signed result word |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The bench builds the block with its default 20 by 20 nest, 5-bit samples, 12-bit accumulator and 6-bit results. This size is small enough to check every one of the 400 steps of each sweep cycle by cycle against sums computed arithmetically. Tables of constant maximum and minimum samples push the weighted sum past the 12-bit range, which exercises both the accumulator wrap and the 6-bit truncation of the quotient. Ramp, alternating and pseudo-random tables cover mixed signs and toward-zero rounding. Starts and writes injected mid-sweep, and writes to addresses beyond the table, are then checked through the results of the following sweep.

// File: rtl/ers_pkg.sv
package ers_pkg;

  // Control word handed from the loop sequencer to the datapath each cycle.
  typedef struct packed {
    logic valid;       // a step is executed this cycle
    logic first;       // inner index is zero
    logic last;        // inner index is at its final value
    logic final_step;  // last inner step of the last outer row
  } ers_step_t;

endpackage

// File: rtl/ers_sample_store.sv
module ers_sample_store #(
  parameter int DEPTH = 20,
  parameter int SW    = 5,
  parameter int AW    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [SW-1:0]        wr_data,
  input  logic                 lock,
  input  logic [AW-1:0]        rd_addr,
  output logic signed [SW-1:0] rd_data
);

  logic [DEPTH-1:0][SW-1:0] mem;
  logic                     wr_ok;
  logic                     rd_ok;

  // Write accepted only when idle and inside the table.
  assign wr_ok = wr_en && !lock && ({1'b0, wr_addr} < (AW+1)'(DEPTH));
  assign rd_ok = ({1'b0, rd_addr} < (AW+1)'(DEPTH));

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    logic entry_we;
    assign entry_we = wr_ok && (wr_addr == AW'(k));
    always_ff @(posedge clk) begin
      if (entry_we) begin
        mem[k] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_ok) begin
      rd_data = $signed(mem[rd_addr]);
    end
  end

  // R9: table frozen during a sweep
  p_table_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(mem));

endmodule

// File: rtl/ers_loop_ctrl.sv
module ers_loop_ctrl
  import ers_pkg::*;
#(
  parameter int N_OUTER = 20,
  parameter int N_INNER = 20,
  parameter int IW      = 5,
  parameter int JW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output ers_step_t     step,
  output logic [IW-1:0] i_idx,
  output logic [JW-1:0] j_idx,
  output logic          busy
);

  localparam logic [IW-1:0] LAST_I = IW'(N_OUTER - 1);
  localparam logic [JW-1:0] LAST_J = JW'(N_INNER - 1);

  logic          busy_q, busy_d;
  logic [IW-1:0] i_q, i_d;
  logic [JW-1:0] j_q, j_d;
  logic          j_last, i_last;

  assign j_last = (j_q == LAST_J);
  assign i_last = (i_q == LAST_I);

  // Next-state: flattened counter pair, one inner step per cycle.
  always_comb begin
    busy_d = busy_q;
    i_d    = i_q;
    j_d    = j_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        i_d    = '0;
        j_d    = '0;
      end
    end else if (j_last) begin
      j_d = '0;
      if (i_last) begin
        busy_d = 1'b0;
      end else begin
        i_d = i_q + 1'b1;
      end
    end else begin
      j_d = j_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      i_q    <= '0;
      j_q    <= '0;
    end else begin
      busy_q <= busy_d;
      i_q    <= i_d;
      j_q    <= j_d;
    end
  end

  assign busy             = busy_q;
  assign i_idx            = i_q;
  assign j_idx            = j_q;
  assign step.valid       = busy_q;
  assign step.first       = busy_q && (j_q == '0);
  assign step.last        = busy_q && j_last;
  assign step.final_step  = busy_q && j_last && i_last;

  // R2: inner index advances by one inside a row
  p_inner_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !j_last |=> busy_q && (j_q == JW'($past(j_q) + 1'b1)) && (i_q == $past(i_q)));

  // R2: sweep ends after the final step
  p_sweep_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && j_last && i_last |=> !busy_q);

  // R8: a start during a sweep never rewinds the counters
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start && !(j_last && i_last) |=> busy_q && !((i_q == '0) && (j_q == '0)));

endmodule

// File: rtl/ers_mac_unit.sv
module ers_mac_unit
  import ers_pkg::*;
#(
  parameter int N_OUTER = 20,
  parameter int SW      = 5,
  parameter int ACC_W   = 12,
  parameter int OUT_W   = 6,
  parameter int DIVISOR = 20,
  parameter int IW      = 5,
  parameter int JW      = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ers_step_t               step,
  input  logic [IW-1:0]           i_idx,
  input  logic [JW-1:0]           j_idx,
  input  logic signed [SW-1:0]    sample,
  output logic                    res_valid,
  output logic [IW-1:0]           res_index,
  output logic signed [OUT_W-1:0] res_data,
  output logic                    done
);

  localparam logic signed [ACC_W-1:0] DIV_S  = ACC_W'(DIVISOR);
  localparam logic [IW-1:0]           LAST_I = IW'(N_OUTER - 1);

  logic signed [ACC_W-1:0] samp_ext, j_ext, prod;
  logic signed [ACC_W-1:0] acc_base, acc_sum, quot;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [OUT_W-1:0] row_word;
  logic                    vld_q, vld_d;
  logic [IW-1:0]           idx_q, idx_d;
  logic signed [OUT_W-1:0] dat_q, dat_d;
  logic                    fin_q, fin_d;
  logic                    done_q, done_d;

  // Datapath: one multiply-accumulate per step, wrapping at ACC_W bits.
  always_comb begin
    samp_ext = {{(ACC_W-SW){sample[SW-1]}}, sample};
    j_ext    = $signed(ACC_W'(j_idx));
    prod     = samp_ext * j_ext;
    acc_base = step.first ? '0 : acc_q;
    acc_sum  = acc_base + prod;
    quot     = acc_sum / DIV_S;
    row_word = i_idx[0] ? '0 : quot[OUT_W-1:0];
  end

  // Next-state with explicit enables.
  always_comb begin
    acc_d  = step.valid ? acc_sum : acc_q;
    vld_d  = step.valid && step.last;
    idx_d  = vld_d ? i_idx : idx_q;
    dat_d  = vld_d ? row_word : dat_q;
    fin_d  = step.valid && step.final_step;
    done_d = fin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      vld_q  <= 1'b0;
      idx_q  <= '0;
      dat_q  <= '0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      vld_q  <= vld_d;
      idx_q  <= idx_d;
      dat_q  <= dat_d;
      fin_q  <= fin_d;
      done_q <= done_d;
    end
  end

  assign res_valid = vld_q;
  assign res_index = idx_q;
  assign res_data  = dat_q;
  assign done      = done_q;

  // R4: result strobe lasts a single cycle
  p_result_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R6: odd rows report zero
  p_odd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && idx_q[0] |-> (dat_q == '0));

  // R7: done follows the final row's result
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(vld_q) && ($past(idx_q) == LAST_I));

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/ers_accum.sv
module ers_accum
  import ers_pkg::*;
#(
  parameter int N_OUTER = 20,
  parameter int N_INNER = 20,
  parameter int SW      = 5,
  parameter int ACC_W   = 12,
  parameter int OUT_W   = 6,
  parameter int DIVISOR = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(N_INNER)-1:0]  wr_addr,
  input  logic [SW-1:0]               wr_data,
  input  logic                        start,
  output logic                        busy,
  output logic                        res_valid,
  output logic [$clog2(N_OUTER)-1:0]  res_index,
  output logic [OUT_W-1:0]            res_data,
  output logic                        done
);

  localparam int IW = $clog2(N_OUTER);
  localparam int JW = $clog2(N_INNER);

  ers_step_t               step;
  logic [IW-1:0]           i_idx;
  logic [JW-1:0]           j_idx;
  logic signed [SW-1:0]    sample;
  logic signed [OUT_W-1:0] res_word;

  ers_loop_ctrl #(
    .N_OUTER (N_OUTER),
    .N_INNER (N_INNER),
    .IW      (IW),
    .JW      (JW)
  ) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .step  (step),
    .i_idx (i_idx),
    .j_idx (j_idx),
    .busy  (busy)
  );

  ers_sample_store #(
    .DEPTH (N_INNER),
    .SW    (SW),
    .AW    (JW)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .lock    (busy),
    .rd_addr (j_idx),
    .rd_data (sample)
  );

  ers_mac_unit #(
    .N_OUTER (N_OUTER),
    .SW      (SW),
    .ACC_W   (ACC_W),
    .OUT_W   (OUT_W),
    .DIVISOR (DIVISOR),
    .IW      (IW),
    .JW      (JW)
  ) u_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .i_idx     (i_idx),
    .j_idx     (j_idx),
    .sample    (sample),
    .res_valid (res_valid),
    .res_index (res_index),
    .res_data  (res_word),
    .done      (done)
  );

  assign res_data = res_word;

  // R2: busy rises on the clock after an idle start
  p_start_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);

endmodule

// File: tb/ers_accum_test.sv
`timescale 1ns/1ps
module ers_accum_test;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [4:0] wr_addr;
  logic [4:0] wr_data;
  logic       start;
  logic       busy;
  logic       res_valid;
  logic [4:0] res_index;
  logic [5:0] res_data;
  logic       done;

  int checks   = 0;
  int failures = 0;
  int smp [20];

  ers_accum uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .start     (start),
    .busy      (busy),
    .res_valid (res_valid),
    .res_index (res_index),
    .res_data  (res_data),
    .done      (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected row word from the requirements (R3, R5, R6).
  function automatic int exp_row(int i);
    int s;
    int a;
    int q;
    logic [5:0] w;
    if (i % 2 != 0) return 0;
    s = 0;
    for (int j = 0; j < 20; j++) s += smp[j] * j;
    a = s & 4095;
    if (a >= 2048) a -= 4096;
    q = a / 20;
    w = q[5:0];
    return int'($signed(w));
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a[4:0];
    wr_data = d[4:0];
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 20) smp[a] = d;
  endtask

  task automatic run(string tag, bit poke);
    int exp_i;
    @(negedge clk);
    start = 1'b1;
    for (int c = 1; c <= 405; c++) begin
      bit ev;
      @(negedge clk);
      if (c == 1) start = 1'b0;
      ev = (c >= 21) && (c <= 401) && ((c - 21) % 20 == 0);
      chk({tag, " R2 busy"}, int'(busy), int'(c <= 400));
      chk({tag, " R4 valid"}, int'(res_valid), int'(ev));
      chk({tag, " R7 done"}, int'(done), int'(c == 402));
      if (ev) begin
        exp_i = (c - 21) / 20;
        chk({tag, " R4 index"}, int'(res_index), exp_i);
        if (exp_i % 2 == 0)
          chk({tag, " R3 R5 even word"}, int'($signed(res_data)), exp_row(exp_i));
        else
          chk({tag, " R6 odd word"}, int'($signed(res_data)), 0);
      end
      if (poke) begin
        // R8: start pulse mid-sweep; R9: write mid-sweep
        if (c == 50)  start = 1'b1;
        if (c == 51)  start = 1'b0;
        if (c == 100) begin wr_en = 1'b1; wr_addr = 5'd3; wr_data = 5'd7; end
        if (c == 101) wr_en = 1'b0;
        if (c == 399) start = 1'b1;
        if (c == 400) start = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lfsr;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    start   = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 busy", int'(busy), 0);
    chk("R10 valid", int'(res_valid), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 index", int'(res_index), 0);
    chk("R10 data", int'(res_data), 0);
    rst_n = 1'b1;

    for (int j = 0; j < 20; j++) wr(j, 0);
    run("zeros", 1'b0);

    for (int j = 0; j < 20; j++) wr(j, 15);
    run("max R3 wrap", 1'b0);

    for (int j = 0; j < 20; j++) wr(j, -16);
    run("min R3 wrap", 1'b0);

    for (int j = 0; j < 20; j++) wr(j, j - 10);
    run("ramp R8 R9 poke", 1'b1);

    // R9: the mid-sweep write left the table intact; R1: high addresses ignored
    wr(20, 15);
    wr(25, -16);
    wr(31, 9);
    run("R1 R9 rerun", 1'b0);

    for (int j = 0; j < 20; j++) wr(j, (j % 2 != 0) ? 15 : -16);
    run("alternating", 1'b0);

    lfsr = 32'h1D5;
    for (int j = 0; j < 20; j++) begin
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7FFFFFFF;
      wr(j, ((lfsr >> 8) % 32) - 16);
    end
    run("pseudo-random R1", 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule